// File: doc/BRIEF.md
# End-to-End Packet CRC Engine

This block computes a 32-bit end-to-end CRC over a packet's header and payload while the bytes stream past, one byte per clock. The same engine serves the sending side, where the finished CRC word is taken from `crcOut` and appended as the digest, and the receiving side, where the finished value is compared with the digest word that arrived with the packet.

Bytes arrive with a valid qualifier, start-of-packet and end-of-packet markers, and a flag that tells the engine whether the current byte belongs to the header. Two header bits can legally change while the packet crosses the fabric: bit 0 of the type field and the poisoned-data bit. The engine forces both to 1 before they enter the calculation, so the CRC does not depend on them. When `checkEn` is low the packet carries no digest. The engine still produces the CRC, and no mismatch is ever flagged for that packet.

Top module: `e2e_crc_engine`

## Requirements
- R1: The CRC uses generator polynomial 0x04C11DB7 in a left-shifting 32-bit register. Each data bit d updates the register as follows: the feedback is reg[31] xor d, the register shifts left by one, and the polynomial is XORed in when the feedback is 1. Bytes enter in stream order, and within a byte bit 0 enters first and bit 7 last.
- R2: The register is loaded with 0xFFFFFFFF on the byte marked start-of-packet. Two identical packets therefore give the same CRC, whatever came before them.
- R3: Header byte at offset 0 (the start-of-packet byte): bit 0 is replaced by 1 before accumulation.
- R4: Header byte at offset 2: bit 6 is replaced by 1 before accumulation.
- R5: The masking applies only to bytes with `inHdr` high. Every other header bit, and every payload byte, enters unchanged, so flipping such a bit changes the CRC.
- R6: `crcOut` carries the bitwise inverse of the final register. `crcValid` pulses for exactly one cycle, in the cycle after the clock edge that accepted the end-of-packet byte. `crcOut` holds its value until the next packet ends.
- R7: When `checkEn` is high with the end-of-packet byte, `mismatch` pulses together with `crcValid` exactly when `rxDigest` (bit i compared with `crcOut` bit i) differs from the computed value.
- R8: When `checkEn` is low with the end-of-packet byte, `mismatch` stays low, whatever `rxDigest` holds.
- R9: Cycles with `inValid` low change nothing, including when `inSop`, `inEop` or the data are active in those cycles.
- R10: After reset, `crcValid` and `mismatch` are low and `crcOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Byte qualifier |
| inSop | input | 1 | Current byte is the first of a packet |
| inEop | input | 1 | Current byte is the last of a packet |
| inHdr | input | 1 | Current byte is a header byte |
| inByte | input | 8 | Stream byte |
| checkEn | input | 1 | Packet carries a digest; compare at end of packet |
| rxDigest | input | 32 | Received digest word, sampled with the end-of-packet byte |
| crcOut | output | 32 | Final inverted CRC of the last completed packet |
| crcValid | output | 1 | One-cycle pulse when `crcOut` is updated |
| mismatch | output | 1 | Digest compare failed, pulses with `crcValid` |

## Verification
Every result of this block is due in one place. After the rising edge that accepts the end-of-packet byte, `crcValid`, `crcOut` and `mismatch` all appear together, and `crcValid` drops again one cycle later. The bench drives inputs on falling edges. It samples the three results on the falling edge right after the end-of-packet edge, and samples again one cycle on to confirm the pulse width. For the checks on variant bits and on ignored idle cycles, the bench compares these port values across packets that differ only in the bit or cycle under test.

// File: rtl/e2e_crc_pkg.sv
package e2e_crc_pkg;
  localparam int CRC_W = 32;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam int TYPE_OFS = 0;
  localparam int TYPE_BIT = 0;
  localparam int POISON_OFS = 2;
  localparam int POISON_BIT = 6;

  typedef struct packed {
    logic adv;       // accept a byte
    logic seed;      // start from seed value
    logic fin;       // last byte of packet
    logic maskType;  // force type-field bit
    logic maskPsn;   // force poisoned bit
  } crc_strobe_t;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] cur,
                                               input logic [BYTE_W-1:0] dat);
    logic [CRC_W-1:0] r;
    logic fb;
    r = cur;
    for (int k = 0; k < BYTE_W; k++) begin
      fb = r[CRC_W-1] ^ dat[k];
      r = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/e2e_crc_ctrl.sv
module e2e_crc_ctrl
  import e2e_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSop,
  input  logic        inEop,
  input  logic        inHdr,
  output crc_strobe_t strobe
);
  localparam int MAX_OFS = (POISON_OFS > TYPE_OFS) ? POISON_OFS : TYPE_OFS;
  localparam int CNT_W = $clog2(MAX_OFS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_OFS + 1);

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] curOfs;

  assign curOfs = inSop ? '0 : byteCnt;

  always_comb begin
    strobe.adv      = inValid;
    strobe.seed     = inValid && inSop;
    strobe.fin      = inValid && inEop;
    strobe.maskType = inValid && inHdr && (curOfs == CNT_W'(TYPE_OFS));
    strobe.maskPsn  = inValid && inHdr && (curOfs == CNT_W'(POISON_OFS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteCnt <= '0;
    else if (inValid) begin
      if (curOfs != CNT_SAT) byteCnt <= curOfs + 1'b1;
      else byteCnt <= curOfs;
    end
  end

  // R2
  sop_restarts_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSop) |=> (byteCnt == CNT_W'(1)));

  // R9
  idle_keeps_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(byteCnt));
endmodule

// File: rtl/e2e_crc_dp.sv
module e2e_crc_dp
  import e2e_crc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  crc_strobe_t       strobe,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              checkEn,
  input  logic [CRC_W-1:0]  rxDigest,
  output logic [CRC_W-1:0]  crcOut,
  output logic              crcValid,
  output logic              mismatch
);
  logic [CRC_W-1:0]  crcReg;
  logic [CRC_W-1:0]  baseCrc;
  logic [CRC_W-1:0]  nextCrc;
  logic [BYTE_W-1:0] useByte;

  always_comb begin
    useByte = inByte;
    if (strobe.maskType) useByte[TYPE_BIT] = 1'b1;
    if (strobe.maskPsn) useByte[POISON_BIT] = 1'b1;
    baseCrc = strobe.seed ? CRC_SEED : crcReg;
    nextCrc = crcByte(baseCrc, useByte);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg   <= CRC_SEED;
      crcOut   <= '0;
      crcValid <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      crcValid <= strobe.fin;
      mismatch <= strobe.fin && checkEn && ((~nextCrc) != rxDigest);
      if (strobe.fin) begin
        crcReg <= CRC_SEED;
        crcOut <= ~nextCrc;
      end else if (strobe.adv) begin
        crcReg <= nextCrc;
      end
    end
  end

  // R9
  idle_holds_crc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.adv |=> $stable(crcReg));

  // R6
  valid_follows_eop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fin |=> crcValid);

  // R6
  out_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fin |=> ($stable(crcOut) && !crcValid));

  // R7
  mismatch_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |-> crcValid);

  // R8
  no_digest_no_mismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fin && !checkEn) |=> !mismatch);
endmodule

// File: rtl/e2e_crc_engine.sv
module e2e_crc_engine
  import e2e_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSop,
  input  logic        inEop,
  input  logic        inHdr,
  input  logic [7:0]  inByte,
  input  logic        checkEn,
  input  logic [31:0] rxDigest,
  output logic [31:0] crcOut,
  output logic        crcValid,
  output logic        mismatch
);
  crc_strobe_t strobe;

  e2e_crc_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSop   (inSop),
    .inEop   (inEop),
    .inHdr   (inHdr),
    .strobe  (strobe)
  );

  e2e_crc_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inByte   (inByte),
    .checkEn  (checkEn),
    .rxDigest (rxDigest),
    .crcOut   (crcOut),
    .crcValid (crcValid),
    .mismatch (mismatch)
  );
endmodule

// File: tb/test_e2e_crc_engine.sv
module test_e2e_crc_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0, inHdr = 1'b0;
  logic [7:0] inByte = '0;
  logic checkEn = 1'b0;
  logic [31:0] rxDigest = '0;
  logic [31:0] crcOut;
  logic crcValid, mismatch;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  e2e_crc_engine i_e2e_crc_engine (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inHdr(inHdr), .inByte(inByte), .checkEn(checkEn), .rxDigest(rxDigest),
    .crcOut(crcOut), .crcValid(crcValid), .mismatch(mismatch)
  );

  typedef struct packed {
    logic [127:0] data;
    logic [4:0]   len;
    logic [4:0]   hdr;
    logic         ce;
    logic         corrupt;
    logic [3:0]   gap;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{128'h0, 5'd1, 5'd1, 1'b1, 1'b0, 4'd0},
    '{128'h44332211_00000001_0000_0000_5040_0074, 5'd16, 5'd16, 1'b1, 1'b0, 4'd0},
    '{128'hDEADBEEF_00000000_1234_0000_0100_0070, 5'd12, 5'd8, 1'b1, 1'b1, 4'd0},
    '{128'h0_A5A55A5A_FF00FF00_01020304, 5'd12, 5'd4, 1'b0, 1'b1, 4'd0},
    '{128'h0_0000_00FF_FF7F_FFFF, 5'd8, 5'd4, 1'b1, 1'b0, 4'd2},
    '{128'h0_CAFE_F00D_0BAD_C0DE, 5'd8, 5'd0, 1'b1, 1'b1, 4'd1},
    '{128'h0_0000_0000_0000_0041, 5'd2, 5'd2, 1'b1, 1'b0, 4'd3}
  };

  function automatic logic [31:0] refCrc(input logic [127:0] d, input int len, input int hdr);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [7:0] b;
    logic fb;
    for (int i = 0; i < len; i++) begin
      b = d[i*8 +: 8];
      if (i < hdr && i == 0) b[0] = 1'b1;
      if (i < hdr && i == 2) b[6] = 1'b1;
      for (int k = 0; k < 8; k++) begin
        fb = c[31] ^ b[k];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    end
    return ~c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] gotCrc;
  logic gotMm, gotVld, gotVld2;

  // drives on falling edges; results sampled on the falling edge after the EOP edge
  task automatic sendPkt(input logic [127:0] d, input int len, input int hdr,
                         input logic [31:0] dig, input logic ce, input int gap);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1; inSop = (i == 0); inEop = (i == len - 1);
      inHdr = (i < hdr); inByte = d[i*8 +: 8];
      checkEn = ce; rxDigest = dig;
      @(posedge clk); @(negedge clk);
      if (i != len - 1) begin
        for (int g = 0; g < gap; g++) begin
          inValid = 1'b0; inSop = 1'b1; inEop = 1'b1; inHdr = 1'b1;
          inByte = 8'hA5 ^ 8'(g); checkEn = 1'b1; rxDigest = 32'h1;
          @(posedge clk); @(negedge clk);
        end
      end
    end
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0; inHdr = 1'b0; inByte = '0;
    checkEn = 1'b0; rxDigest = '0;
    gotCrc = crcOut; gotMm = mismatch; gotVld = crcValid;
    @(posedge clk); @(negedge clk);
    gotVld2 = crcValid;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] e, crcA, crcB;
    logic [127:0] p;
    repeat (3) @(negedge clk);
    // R10
    chk("R10 crcValid", {31'b0, crcValid}, 32'h0);
    chk("R10 mismatch", {31'b0, mismatch}, 32'h0);
    chk("R10 crcOut", crcOut, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R1 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      e = refCrc(VEC[v].data, int'(VEC[v].len), int'(VEC[v].hdr));
      sendPkt(VEC[v].data, int'(VEC[v].len), int'(VEC[v].hdr),
              VEC[v].corrupt ? (e ^ 32'h0000_0100) : e, VEC[v].ce, int'(VEC[v].gap));
      chk("R1 crc value", gotCrc, e);
      chk("R6 valid pulse", {30'b0, gotVld, gotVld2}, 32'h2);
      if (VEC[v].ce) chk("R7 mismatch", {31'b0, gotMm}, {31'b0, VEC[v].corrupt});
      else chk("R8 no digest", {31'b0, gotMm}, 32'h0);
      if (VEC[v].gap != 0) chk("R9 idle ignored", gotCrc, e);
    end

    // R6: crcOut holds after the pulse
    chk("R6 hold", crcOut, refCrc(VEC[NVEC-1].data, 2, 2));

    // R2: identical packets back to back
    p = 128'h0_1111_2222_3333_4444;
    sendPkt(p, 8, 4, 32'h0, 1'b0, 0); crcA = gotCrc;
    sendPkt(p, 8, 4, 32'h0, 1'b0, 0); crcB = gotCrc;
    chk("R2 reseed", crcB, crcA);

    // R3: type bit 0 of byte 0 is don't-care
    p = 128'h0_0000_0000_0000_0070;
    sendPkt(p, 8, 8, 32'h0, 1'b0, 0); crcA = gotCrc;
    sendPkt(p | 128'h1, 8, 8, 32'h0, 1'b0, 0); crcB = gotCrc;
    chk("R3 type bit masked", crcB, crcA);

    // R4: byte 2 bit 6 is don't-care
    sendPkt(p | 128'h40_0000, 8, 8, 32'h0, 1'b0, 0); crcB = gotCrc;
    chk("R4 poison bit masked", crcB, crcA);

    // R5: neighbouring header bit is included
    sendPkt(p | 128'h2, 8, 8, 32'h0, 1'b0, 0); crcB = gotCrc;
    chk("R5 header bit included", {31'b0, crcB != crcA}, 32'h1);

    // R5: byte 2 bit 6 in payload is included
    sendPkt(p, 8, 2, 32'h0, 1'b0, 0); crcA = gotCrc;
    sendPkt(p | 128'h40_0000, 8, 2, 32'h0, 1'b0, 0); crcB = gotCrc;
    chk("R5 payload bit included", {31'b0, crcB != crcA}, 32'h1);
    chk("R5 payload crc", crcB, refCrc(p | 128'h40_0000, 8, 2));

    // R8: wrong digest without checkEn
    sendPkt(p, 4, 4, 32'hFFFF_FFFF, 1'b0, 0);
    chk("R8 digest ignored", {31'b0, gotMm}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule